// File: doc/BRIEF.md
# Sequential Memory Window Attach Controller

This block is the control and status register set of a device that exposes a large memory aperture. A driver fills the aperture with backing windows, one after another, by programming a window size and a backing offset and then ringing a doorbell. The block keeps a fill pointer into the aperture. On an attach command it checks alignment and capacity. If the checks pass, it places the new window at the fill pointer and moves the pointer past the window. A detach command removes every window at once and rewinds the pointer to zero.

Each outcome sets a bit in a sticky status register, and an interrupt line stays high while an unmasked status bit is set. Reading the status register returns the accumulated bits and clears them. A successful attach emits a one-cycle programming strobe that carries the aperture offset, the size and the backing offset, for the logic that does the real mapping. A detach emits a one-cycle clear-all strobe. The register port takes 32-bit accesses and 64-bit accesses. A 64-bit register can be reached either whole or as two 32-bit halves.

Top module: `memwin_attach_top`

## Requirements
- R1: After reset the mask, the status, the fill pointer and the window count are zero, and `irq` is low.
- R2: A doorbell write (byte offset 0x08) acts only when bit 31 is 1. Code 1 in bits 15:0 means attach and code 2 means detach all. Every other code, and any write with bit 31 clear, changes no state and produces no strobe.
- R3: On attach, if the size or the current fill pointer is not a multiple of `ALIGN_BYTES`, no window is made, the fill pointer is unchanged and status bit 3 is set.
- R4: A successful attach raises `winValid` for exactly one cycle. It carries the old fill pointer on `winApOffset`, the size register on `winSize` and the backing-offset register on `winBackOffset`. The fill pointer grows by the size, and status bit 0 is set.
- R5: Detach all resets the fill pointer and the window count to zero, raises `winClearAll` for one cycle and sets status bit 1.
- R6: An aligned attach is rejected if fill+size would exceed `APERTURE_BYTES` or if `MAX_WIN` windows are already attached. A rejected attach sets status bit 2, leaves the fill pointer unchanged and produces no strobe. The alignment check takes priority over these checks.
- R7: A read of status (0x04) returns the accumulated 5-bit status and clears it. Writes to status have no effect.
- R8: The mask register (0x00, 5 bits) reads back as written. `irq` is high exactly when (status AND NOT mask) is nonzero.
- R9: The size (0x18) and backing-offset (0x20) registers take a 64-bit access at the base address. A 32-bit write at the base replaces only bits 31:0, and a 32-bit write at base+4 replaces only bits 63:32. 32-bit reads at the base and at base+4 return the low half and the high half.
- R10: Alignment (0x0C) reads as `ALIGN_BYTES`. The fill pointer (0x10/0x14) reads as its value and ignores writes. The doorbell and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (never together with a write) |
| regWide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| regAddr | input | 6 | Byte offset of the register |
| regWrData | input | 64 | Write data (32-bit writes use bits 31:0) |
| regRdData | output | 64 | Read data, combinational from the current address |
| irq | output | 1 | Level interrupt: unmasked status pending |
| winValid | output | 1 | One-cycle strobe for a newly attached window |
| winApOffset | output | 64 | Aperture offset of the new window |
| winSize | output | 64 | Size of the new window |
| winBackOffset | output | 64 | Backing offset of the new window |
| winClearAll | output | 1 | One-cycle strobe: remove all windows |

## Verification
The assertions check these properties on every cycle:
- the fill pointer stays aligned and inside the aperture;
- the window count never exceeds the table size;
- a programming strobe only follows an attach command and a clear-all strobe only follows a detach;
- a detach leaves the pointer at zero;
- a status read with no command in the same cycle leaves status empty.

The exact status codes need the bench's scenarios to show them, because they depend on the order of checks:
- alignment before capacity;
- the aperture limit against a full table;
- what happens to the status bits when a read clears them between commands.

The scenarios also show whether the split 32/64-bit halves land in the right place, and whether strobe fields equal the values software programmed.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

  // read source selected by the address decoder
  typedef enum logic [2:0] {
    RD_NONE,
    RD_MASK,
    RD_STATUS,
    RD_ALIGN,
    RD_FILL,
    RD_SIZE,
    RD_BACK
  } rdSel_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic   wrMask;
    logic   wrSizeLo;
    logic   wrSizeHi;
    logic   wrBackLo;
    logic   wrBackHi;
    logic   wrWide;
    logic   rdStatus;
    logic   cmdAttach;
    logic   cmdDetach;
    rdSel_e rdSel;
    logic   rdHigh;
    logic   rdWide;
  } ctrlStrobe_t;

  // status bit positions
  localparam int ST_ATTACH_OK = 0;
  localparam int ST_DETACH_OK = 1;
  localparam int ST_NO_ROOM   = 2;
  localparam int ST_ALIGN_ERR = 3;
  localparam int ST_UNMAPPED  = 4;
  localparam int ST_W         = 5;

  localparam logic [15:0] CMD_ATTACH = 16'd1;
  localparam logic [15:0] CMD_DETACH = 16'd2;

endpackage

// File: rtl/memwin_ctrl.sv
module memwin_ctrl
  import memwin_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cmdEn,
  input  logic [15:0]       cmdCode,
  output ctrlStrobe_t       strobe
);

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_NONE;
    strobe.rdWide = wide;
    unique case (addr)
      ADDR_W'(6'h00): begin
        strobe.wrMask = wrEn;
        strobe.rdSel  = RD_MASK;
      end
      ADDR_W'(6'h04): begin
        strobe.rdStatus = rdEn;
        strobe.rdSel    = RD_STATUS;
      end
      ADDR_W'(6'h08): begin
        strobe.cmdAttach = wrEn && cmdEn && (cmdCode == CMD_ATTACH);
        strobe.cmdDetach = wrEn && cmdEn && (cmdCode == CMD_DETACH);
      end
      ADDR_W'(6'h0C): strobe.rdSel = RD_ALIGN;
      ADDR_W'(6'h10): strobe.rdSel = RD_FILL;
      ADDR_W'(6'h14): begin
        strobe.rdSel  = RD_FILL;
        strobe.rdHigh = 1'b1;
        strobe.rdWide = 1'b0;
      end
      ADDR_W'(6'h18): begin
        strobe.rdSel    = RD_SIZE;
        strobe.wrSizeLo = wrEn;
        strobe.wrSizeHi = wrEn && wide;
        strobe.wrWide   = wide;
      end
      ADDR_W'(6'h1C): begin
        strobe.rdSel    = RD_SIZE;
        strobe.rdHigh   = 1'b1;
        strobe.rdWide   = 1'b0;
        strobe.wrSizeHi = wrEn;
      end
      ADDR_W'(6'h20): begin
        strobe.rdSel    = RD_BACK;
        strobe.wrBackLo = wrEn;
        strobe.wrBackHi = wrEn && wide;
        strobe.wrWide   = wide;
      end
      ADDR_W'(6'h24): begin
        strobe.rdSel    = RD_BACK;
        strobe.rdHigh   = 1'b1;
        strobe.rdWide   = 1'b0;
        strobe.wrBackHi = wrEn;
      end
      default: ;
    endcase
  end

  // R2
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cmdAttach, strobe.cmdDetach}));

endmodule

// File: rtl/memwin_dp.sv
module memwin_dp
  import memwin_pkg::*;
#(
  parameter longint unsigned ALIGN_BYTES    = 64'h4000_0000,
  parameter longint unsigned APERTURE_BYTES = 64'h2_0000_0000,
  parameter int              MAX_WIN        = 8,
  parameter int              DATA_W         = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              winValid,
  output logic [DATA_W-1:0] winApOffset,
  output logic [DATA_W-1:0] winSize,
  output logic [DATA_W-1:0] winBackOffset,
  output logic              winClearAll
);

  localparam int               HALF_W     = DATA_W / 2;
  localparam int               CNT_W      = $clog2(MAX_WIN + 1);
  localparam logic [DATA_W-1:0] ALIGN_MASK = DATA_W'(ALIGN_BYTES) - DATA_W'(1);
  localparam logic [DATA_W:0]   APER_EXT   = {1'b0, DATA_W'(APERTURE_BYTES)};
  localparam logic [HALF_W-1:0] ALIGN_RD   = HALF_W'(ALIGN_BYTES);

  logic [ST_W-1:0]   maskQ, statusQ, setBits;
  logic [DATA_W-1:0] fillQ, sizeQ, backQ;
  logic [CNT_W-1:0]  countQ;
  logic [DATA_W:0]   fillSum;
  logic              misaligned, noRoom, attachOk;
  logic [DATA_W-1:0] rdSrc;
  logic [HALF_W-1:0] hiWord;

  // attach qualification
  assign misaligned = |((sizeQ | fillQ) & ALIGN_MASK);
  assign fillSum    = {1'b0, fillQ} + {1'b0, sizeQ};
  assign noRoom     = (countQ == CNT_W'(MAX_WIN)) || (fillSum > APER_EXT);
  assign attachOk   = strobe.cmdAttach && !misaligned && !noRoom;

  always_comb begin
    setBits = '0;
    if (strobe.cmdAttach) begin
      if (misaligned)  setBits[ST_ALIGN_ERR] = 1'b1;
      else if (noRoom) setBits[ST_NO_ROOM]   = 1'b1;
      else             setBits[ST_ATTACH_OK] = 1'b1;
    end
    if (strobe.cmdDetach) setBits[ST_DETACH_OK] = 1'b1;
  end

  assign hiWord = strobe.wrWide ? wrData[DATA_W-1:HALF_W] : wrData[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ         <= '0;
      statusQ       <= '0;
      fillQ         <= '0;
      sizeQ         <= '0;
      backQ         <= '0;
      countQ        <= '0;
      winValid      <= 1'b0;
      winClearAll   <= 1'b0;
      winApOffset   <= '0;
      winSize       <= '0;
      winBackOffset <= '0;
    end else begin
      winValid    <= attachOk;
      winClearAll <= strobe.cmdDetach;
      if (strobe.wrMask)   maskQ <= wrData[ST_W-1:0];
      if (strobe.wrSizeLo) sizeQ[HALF_W-1:0]      <= wrData[HALF_W-1:0];
      if (strobe.wrSizeHi) sizeQ[DATA_W-1:HALF_W] <= hiWord;
      if (strobe.wrBackLo) backQ[HALF_W-1:0]      <= wrData[HALF_W-1:0];
      if (strobe.wrBackHi) backQ[DATA_W-1:HALF_W] <= hiWord;
      statusQ <= (strobe.rdStatus ? '0 : statusQ) | setBits;
      if (attachOk) begin
        winApOffset   <= fillQ;
        winSize       <= sizeQ;
        winBackOffset <= backQ;
        fillQ         <= fillSum[DATA_W-1:0];
        countQ        <= countQ + CNT_W'(1);
      end else if (strobe.cmdDetach) begin
        fillQ  <= '0;
        countQ <= '0;
      end
    end
  end

  assign irq = |(statusQ & ~maskQ);

  always_comb begin
    unique case (strobe.rdSel)
      RD_MASK:   rdSrc = DATA_W'(maskQ);
      RD_STATUS: rdSrc = DATA_W'(statusQ);
      RD_ALIGN:  rdSrc = DATA_W'(ALIGN_RD);
      RD_FILL:   rdSrc = fillQ;
      RD_SIZE:   rdSrc = sizeQ;
      RD_BACK:   rdSrc = backQ;
      default:   rdSrc = '0;
    endcase
    if (strobe.rdWide)      rdData = rdSrc;
    else if (strobe.rdHigh) rdData = DATA_W'(rdSrc[DATA_W-1:HALF_W]);
    else                    rdData = DATA_W'(rdSrc[HALF_W-1:0]);
  end

  // R3
  fill_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillQ & ALIGN_MASK) == '0);

  // R6
  fill_in_aperture_chk: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, fillQ} <= APER_EXT);

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(MAX_WIN));

  // R4
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> $past(strobe.cmdAttach));

  // R5
  detach_rewind_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmdDetach |=> (fillQ == '0 && countQ == '0 && winClearAll));

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdStatus && !strobe.cmdAttach && !strobe.cmdDetach) |=> statusQ == '0);

endmodule

// File: rtl/memwin_attach_top.sv
module memwin_attach_top
  import memwin_pkg::*;
#(
  parameter longint unsigned ALIGN_BYTES    = 64'h4000_0000,
  parameter longint unsigned APERTURE_BYTES = 64'h2_0000_0000,
  parameter int              MAX_WIN        = 8,
  parameter int              ADDR_W         = 6,
  parameter int              DATA_W         = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regWide,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq,
  output logic              winValid,
  output logic [DATA_W-1:0] winApOffset,
  output logic [DATA_W-1:0] winSize,
  output logic [DATA_W-1:0] winBackOffset,
  output logic              winClearAll
);

  ctrlStrobe_t strobe;

  memwin_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (regWrEn),
    .rdEn    (regRdEn),
    .wide    (regWide),
    .addr    (regAddr),
    .cmdEn   (regWrData[31]),
    .cmdCode (regWrData[15:0]),
    .strobe  (strobe)
  );

  memwin_dp #(
    .ALIGN_BYTES    (ALIGN_BYTES),
    .APERTURE_BYTES (APERTURE_BYTES),
    .MAX_WIN        (MAX_WIN),
    .DATA_W         (DATA_W)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrData        (regWrData),
    .rdData        (regRdData),
    .irq           (irq),
    .winValid      (winValid),
    .winApOffset   (winApOffset),
    .winSize       (winSize),
    .winBackOffset (winBackOffset),
    .winClearAll   (winClearAll)
  );

endmodule

// File: tb/sim_memwin_attach_top.sv
module sim_memwin_attach_top;

  localparam longint unsigned AL = 64'h1000;
  localparam longint unsigned AP = 64'h10_0000;
  localparam int MW = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, regWide = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData, winApOffset, winSize, winBackOffset;
  logic        irq, winValid, winClearAll;

  int checks = 0;
  int errors = 0;

  // model state
  logic [4:0]  mMask = '0, mStatus = '0;
  logic [63:0] mFill = '0, mSize = '0, mBack = '0;
  int          mCount = 0;

  always #4 clk = ~clk;

  memwin_attach_top #(.ALIGN_BYTES(AL), .APERTURE_BYTES(AP), .MAX_WIN(MW)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regWide(regWide),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .winValid(winValid), .winApOffset(winApOffset), .winSize(winSize),
    .winBackOffset(winBackOffset), .winClearAll(winClearAll)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expRead(input logic [5:0] a, input bit w);
    case (a)
      6'h00: return 64'(mMask);
      6'h04: return 64'(mStatus);
      6'h0C: return AL;
      6'h10: return w ? mFill : 64'(mFill[31:0]);
      6'h14: return 64'(mFill[63:32]);
      6'h18: return w ? mSize : 64'(mSize[31:0]);
      6'h1C: return 64'(mSize[63:32]);
      6'h20: return w ? mBack : 64'(mBack[31:0]);
      6'h24: return 64'(mBack[63:32]);
      default: return 64'd0;
    endcase
  endfunction

  task automatic doRead(input logic [5:0] a, input bit w, input string req);
    logic [63:0] got, exp;
    exp = expRead(a, w);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a; regWide = w;
    #1 got = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
    if (a == 6'h04) mStatus = '0;
    chk(req, got, exp);
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [63:0] d, input bit w);
    logic [63:0] oldFill;
    bit expValid, expClear;
    logic [64:0] sum;
    oldFill = mFill; expValid = 0; expClear = 0;
    case (a)
      6'h00: mMask = d[4:0];
      6'h18: if (w) mSize = d; else mSize[31:0] = d[31:0];
      6'h1C: mSize[63:32] = d[31:0];
      6'h20: if (w) mBack = d; else mBack[31:0] = d[31:0];
      6'h24: mBack[63:32] = d[31:0];
      6'h08: if (d[31]) begin
        if (d[15:0] == 16'd1) begin
          sum = {1'b0, mFill} + {1'b0, mSize};
          if (((mSize | mFill) & (AL - 1)) != 0) mStatus[3] = 1'b1;
          else if (mCount == MW || sum > {1'b0, AP}) mStatus[2] = 1'b1;
          else begin
            expValid = 1; mFill = sum[63:0]; mCount++; mStatus[0] = 1'b1;
          end
        end else if (d[15:0] == 16'd2) begin
          expClear = 1; mFill = '0; mCount = 0; mStatus[1] = 1'b1;
        end
      end
      default: ;
    endcase
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWide = w; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 6'h08) begin
      chk("R2/R4 winValid", 64'(winValid), 64'(expValid));
      chk("R2/R5 winClearAll", 64'(winClearAll), 64'(expClear));
      if (expValid) begin
        chk("R4 apOffset", winApOffset, oldFill);
        chk("R4 size", winSize, mSize);
        chk("R4 backOffset", winBackOffset, mBack);
      end
      chk("R8 irq", 64'(irq), 64'(|(mStatus & ~mMask)));
      @(negedge clk);
      chk("R4 single-cycle strobe", 64'({winValid, winClearAll}), 64'd0);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 64'(irq), 64'd0);
    doRead(6'h00, 0, "R1 mask");
    doRead(6'h04, 0, "R1 status");
    doRead(6'h10, 1, "R1 fill");
    // R10 read-only / read-zero
    doRead(6'h0C, 0, "R10 align");
    doRead(6'h08, 0, "R10 doorbell reads 0");
    doWrite(6'h10, 64'h5000, 1);
    doRead(6'h10, 1, "R10 fill ignores writes");
    // R9 split access
    doWrite(6'h18, 64'h1111_2222_3333_4444, 1);
    doRead(6'h18, 1, "R9 size wide");
    doWrite(6'h18, 64'hAAAA_0000, 0);
    doRead(6'h18, 1, "R9 size low half write");
    doWrite(6'h1C, 64'h5, 0);
    doRead(6'h1C, 0, "R9 size high half read");
    doWrite(6'h24, 64'h9, 0);
    doRead(6'h20, 1, "R9 back wide read");
    // R3 misaligned attach
    doWrite(6'h18, 64'h1001, 1);
    doWrite(6'h08, 64'h8000_0001, 0);
    doRead(6'h10, 1, "R3 fill unchanged");
    doRead(6'h04, 0, "R3/R7 status align error");
    doRead(6'h04, 0, "R7 status cleared by read");
    // R8 masking
    doWrite(6'h00, 64'h8, 0);
    doWrite(6'h08, 64'h8000_0001, 0);
    chk("R8 masked irq low", 64'(irq), 64'd0);
    doRead(6'h00, 0, "R8 mask readback");
    doWrite(6'h04, 64'h1F, 0);
    doRead(6'h04, 0, "R7 status ignores writes");
    doWrite(6'h00, 64'h0, 0);
    // R2 disabled / unknown codes
    doWrite(6'h18, 64'h3000, 1);
    doWrite(6'h20, 64'h77000, 1);
    doWrite(6'h08, 64'h0000_0001, 0);
    doWrite(6'h08, 64'h8000_0003, 0);
    doRead(6'h04, 0, "R2 ignored command leaves status");
    doRead(6'h10, 1, "R2 ignored command leaves fill");
    // R4 successful attach
    doWrite(6'h08, 64'h8000_0001, 0);
    doRead(6'h10, 1, "R4 fill advanced");
    // R6 aperture overflow
    doWrite(6'h18, AP, 1);
    doWrite(6'h08, 64'h8000_0001, 0);
    doRead(6'h04, 0, "R6 aperture no room");
    // R6 table full
    doWrite(6'h18, 64'h1000, 1);
    for (int i = 0; i < MW; i++) doWrite(6'h08, 64'h8000_0001, 0);
    doRead(6'h04, 0, "R6 table full status");
    doRead(6'h10, 1, "R6 fill after full");
    // R5 detach
    doWrite(6'h08, 64'h8000_0002, 0);
    doRead(6'h10, 1, "R5 fill rewound");
    doRead(6'h04, 0, "R5 detach status");
    // random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0, 1: begin
          logic [63:0] v;
          v = 64'($urandom_range(0, 40)) * AL;
          if ($urandom_range(0, 5) == 0) v = v + 64'($urandom_range(1, 4095));
          if ($urandom_range(0, 1) == 0) doWrite(6'h18, v, 1);
          else doWrite(6'h18, v, 0);
        end
        2: doWrite(6'h1C, 64'($urandom_range(0, 1)), 0);
        3: doWrite(6'h20, {32'($urandom), 32'($urandom)}, $urandom_range(0, 1) == 1);
        4, 5: doWrite(6'h08, 64'h8000_0001, 0);
        6: if ($urandom_range(0, 2) == 0) doWrite(6'h08, 64'h8000_0002, 0);
        7: begin
          logic [5:0] a;
          a = 6'($urandom_range(0, 9) * 4);
          doRead(a, a[2] == 1'b0 && $urandom_range(0, 1) == 1, "R7/R9/R10 random read");
        end
        8: doWrite(6'h00, 64'($urandom_range(0, 31)), 0);
        default: doWrite(6'h08, 64'($urandom), 0);
      endcase
    end
    doRead(6'h04, 0, "R7 final status");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule